// File: doc/BRIEF.md
# L0s Exit Fast-Training Sequencer

This block is the transmit-side controller for the L0s low-power substate of a PCI Express link running at 2.5 or 5 GT/s. While the link is in L0, it watches for a sustained idle period. If power saving for L0s is enabled, it drops the transmitter into electrical idle once a programmable entry latency has passed. When a TLP is waiting to go out, it wakes the lane and sends a burst of Fast Training Sequence ordered sets. It then sends one SKP ordered set, which lets the far receiver lock and return to L0, and goes back to L0 itself.

The per-lane datapath is set by a parameter to carry 1, 2 or 4 symbols per clock. Every ordered set is four symbols long, so each one lasts 4, 2 or 1 clocks. Ordered-set boundaries are tracked in symbols, which keeps the burst length exact at every width. In the normal case the burst length is the programmed FTS count. With the extended-synchronisation control set, the burst is a fixed 4096 FTS, and SKP ordered sets are interleaved at regular intervals. The outputs are per-clock strobes naming the ordered-set type on the lane, a start-of-ordered-set marker, and the state code. Symbol encoding, scrambling and the PHY are handled downstream.

Top module: `l0s_fts_sequencer`

## Requirements
- R1: After reset the state code is 0 (L0) and `os_fts`, `os_skp`, `os_eidle` and `os_sop` are all low.
- R2: With `lnk_ctl[0]` set, the state changes from 0 to 1 (L0s) at the clock edge that ends the `entry_lat`-th consecutive cycle in which `link_idle` is high and `tlp_req` is low. A value of 0 is treated as 1. Any cycle that breaks the run restarts the count.
- R3: While `lnk_ctl[0]` is clear, the state never changes from L0 to L0s, however long the link stays idle.
- R4: In state 1, `os_eidle` is high and the other strobes are low. The state stays 1 until `tlp_req` is sampled high.
- R5: A `tlp_req` sampled high in state 1 starts the exit on the next clock. The state becomes 2 (FTS), or 4 (final SKP) when the burst length is zero, with `os_sop` high.
- R6: With `lnk_ctl[7]` clear, the burst contains exactly `n_fts` FTS ordered sets (0 to 255). A value of 0 goes straight to the final SKP.
- R7: With `lnk_ctl[7]` set, the burst contains exactly 4096 FTS ordered sets, never 4097, at every datapath width.
- R8: With `lnk_ctl[7]` set, one SKP ordered set (state 3) follows every 341st FTS inside the burst. This gives 12 of them, and they do not count toward the FTS total.
- R9: Every burst ends with exactly one SKP ordered set in state 4, then returns to state 0. Each ordered set lasts 4/SYMS clocks, with `os_sop` high on its first clock.
- R10: A `tlp_req` held high during the burst neither shortens nor restarts it. The pending request keeps the block in L0 afterwards.
- R11: With `lnk_ctl[7]` clear, no interleaved SKP (state 3) appears in the burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Lane clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lnk_ctl | input | 8 | Link control: bit 0 enables L0s, bit 7 selects extended synchronisation |
| n_fts | input | 8 | FTS count for a normal exit burst |
| entry_lat | input | LAT_W | Idle cycles needed before entering L0s |
| link_idle | input | 1 | Nothing is queued for transmission |
| tlp_req | input | 1 | A TLP is waiting to be sent |
| os_fts | output | 1 | Lane carries an FTS ordered set this clock |
| os_skp | output | 1 | Lane carries a SKP ordered set this clock |
| os_eidle | output | 1 | Lane is held in electrical idle |
| os_sop | output | 1 | First clock of an ordered set |
| state | output | 3 | 0 L0, 1 L0s, 2 FTS burst, 3 interleaved SKP, 4 final SKP |

## Verification
Normal exits are run with random FTS counts and with the corners 0, 1 and 255. A zero-length burst is told apart from the others by its direct jump to the final SKP, and any off-by-one shows up in the counted FTS starts and in the total burst length in clocks. Extended-synchronisation exits are run with the request pulsed and with it held through the burst. These separate an exact 4096 count from 4097, check that the 12 interleaved SKPs are placed correctly, and check that a late request is ignored. Entry is tried with random latencies, with a latency of zero, with the idle run broken, and with L0s disabled. This separates correct counting from an early or missing entry.

// File: rtl/l0s_pkg.sv
// Package: shared state encoding and ordered-set geometry for the L0s sequencer.
package l0s_pkg;

    // State codes; the numeric values are visible on the top-level state port.
    typedef enum logic [2:0] {
        ST_L0   = 3'd0,
        ST_L0S  = 3'd1,
        ST_FTS  = 3'd2,
        ST_SKPI = 3'd3,
        ST_SKPF = 3'd4
    } l0s_state_e;

    // Every Gen1/Gen2 ordered set handled here spans four symbols.
    localparam int OS_SYMS = 4;

endpackage

// File: rtl/l0s_entry_timer.sv
// Module: l0s_entry_timer
// Counts consecutive qualifying idle cycles and flags the cycle in which the
// programmed entry latency is reached. Assumes the caller deasserts arm
// whenever the run is broken; a latency of zero behaves as one.
module l0s_entry_timer #(
    parameter int LAT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm,
    input  logic [LAT_W-1:0] lat,
    output logic             expire
);

    logic [LAT_W-1:0] run_cnt;
    logic [LAT_W-1:0] lat_eff;

    // Clamp a zero latency to one cycle.
    always_comb lat_eff = (lat == '0) ? {{(LAT_W-1){1'b0}}, 1'b1} : lat;

    // Expire on the cycle that completes the run; >= tolerates a lowered latency.
    always_comb expire = arm && (run_cnt >= (lat_eff - 1'b1));

    // Run-length counter, cleared by any break or by expiry.
    always_ff @(posedge clk) begin
        if (!rst_n)       run_cnt <= '0;
        else if (!arm)    run_cnt <= '0;
        else if (expire)  run_cnt <= '0;
        else              run_cnt <= run_cnt + 1'b1;
    end

    AST_TIMER_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !arm |=> !expire || (lat_eff == {{(LAT_W-1){1'b0}}, 1'b1})); // R2

endmodule

// File: rtl/l0s_os_slicer.sv
// Module: l0s_os_slicer
// Tracks the symbol position inside the current four-symbol ordered set for a
// datapath carrying SYMS symbols per clock (1, 2 or 4). Raises sop on the
// first clock and eop on the last clock of each ordered set while active.
module l0s_os_slicer
    import l0s_pkg::*;
#(
    parameter int SYMS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    output logic sop,
    output logic eop
);

    localparam int          LAST_POS = OS_SYMS - SYMS;
    localparam logic [1:0]  STEP     = 2'(SYMS);
    localparam logic [1:0]  LAST     = 2'(LAST_POS);

    logic [1:0] sym_pos;

    // Boundary flags derived from the symbol position.
    always_comb begin
        sop = active && (sym_pos == 2'd0);
        eop = active && (sym_pos == LAST);
    end

    // Advance by one clock's worth of symbols, wrapping at the ordered-set end.
    always_ff @(posedge clk) begin
        if (!rst_n)       sym_pos <= 2'd0;
        else if (!active) sym_pos <= 2'd0;
        else if (eop)     sym_pos <= 2'd0;
        else              sym_pos <= sym_pos + STEP;
    end

    AST_SOP_FOLLOWS_EOP: assert property (@(posedge clk) disable iff (!rst_n)
        (active && $past(active) && sop) |-> $past(eop)); // R9

endmodule

// File: rtl/l0s_fts_budget.sv
// Module: l0s_fts_budget
// Holds the remaining FTS count of an exit burst and the distance since the
// last interleaved SKP. Loaded once per exit; the extended-sync choice is
// latched at load so later control changes cannot alter a running burst.
module l0s_fts_budget #(
    parameter int NFTS_W  = 8,
    parameter int EXT_FTS = 4096,
    parameter int SKP_GAP = 341
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              ext_sync,
    input  logic [NFTS_W-1:0] n_fts,
    input  logic              fts_done,
    output logic              load_zero,
    output logic              burst_end,
    output logic              skp_due
);

    localparam int CNT_W = $clog2(EXT_FTS + 1);
    localparam int GAP_W = $clog2(SKP_GAP + 1);
    localparam logic [CNT_W-1:0] EXT_CNT  = CNT_W'(EXT_FTS);
    localparam logic [GAP_W-1:0] GAP_LAST = GAP_W'(SKP_GAP - 1);

    logic [CNT_W-1:0] remaining;
    logic [GAP_W-1:0] gap_cnt;
    logic             ext_q;
    logic             final_fts;

    // Decode the burst shape from the counters.
    always_comb begin
        load_zero = !ext_sync && (n_fts == '0);
        final_fts = (remaining == {{(CNT_W-1){1'b0}}, 1'b1});
        burst_end = fts_done && final_fts;
        skp_due   = fts_done && ext_q && (gap_cnt == GAP_LAST) && !final_fts;
    end

    // Remaining-FTS counter: load on wake, decrement per completed FTS.
    always_ff @(posedge clk) begin
        if (!rst_n)        remaining <= '0;
        else if (load)     remaining <= ext_sync ? EXT_CNT : CNT_W'(n_fts);
        else if (fts_done) remaining <= remaining - 1'b1;
    end

    // SKP spacing counter: completed FTS since the last interleaved SKP.
    always_ff @(posedge clk) begin
        if (!rst_n)        gap_cnt <= '0;
        else if (load)     gap_cnt <= '0;
        else if (fts_done) gap_cnt <= (gap_cnt == GAP_LAST) ? '0 : gap_cnt + 1'b1;
    end

    // Latch the sync mode for the whole burst.
    always_ff @(posedge clk) begin
        if (!rst_n)    ext_q <= 1'b0;
        else if (load) ext_q <= ext_sync;
    end

    AST_NO_EXTRA_FTS: assert property (@(posedge clk) disable iff (!rst_n)
        fts_done |-> (remaining != '0)); // R7

    AST_SKP_ONLY_EXT: assert property (@(posedge clk) disable iff (!rst_n)
        skp_due |-> (remaining > {{(CNT_W-1){1'b0}}, 1'b1})); // R8

endmodule

// File: rtl/l0s_fts_sequencer.sv
// Module: l0s_fts_sequencer
// Transmit-side L0s controller. Enters electrical idle after a sustained idle
// period when L0s is enabled, and on a pending TLP sends an FTS burst (with
// interleaved SKPs in extended-sync mode) closed by one SKP before L0.
// Assumes SYMS is 1, 2 or 4 and that inputs are synchronous to clk.
module l0s_fts_sequencer
    import l0s_pkg::*;
#(
    parameter int SYMS    = 2,
    parameter int LAT_W   = 12,
    parameter int NFTS_W  = 8,
    parameter int EXT_FTS = 4096,
    parameter int SKP_GAP = 341
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        lnk_ctl,
    input  logic [NFTS_W-1:0] n_fts,
    input  logic [LAT_W-1:0]  entry_lat,
    input  logic              link_idle,
    input  logic              tlp_req,
    output logic              os_fts,
    output logic              os_skp,
    output logic              os_eidle,
    output logic              os_sop,
    output logic [2:0]        state
);

    localparam int L0S_EN_BIT = 0;
    localparam int EXT_BIT    = 7;

    l0s_state_e st, st_nxt;
    logic       arm, expire;
    logic       in_burst, sop, eop;
    logic       load, fts_done;
    logic       load_zero, burst_end, skp_due;

    // Qualify idle cycles and derive burst controls from the current state.
    always_comb begin
        arm      = (st == ST_L0) && lnk_ctl[L0S_EN_BIT] && link_idle && !tlp_req;
        in_burst = (st == ST_FTS) || (st == ST_SKPI) || (st == ST_SKPF);
        load     = (st == ST_L0S) && tlp_req;
        fts_done = (st == ST_FTS) && eop;
    end

    l0s_entry_timer #(
        .LAT_W (LAT_W)
    ) i_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .arm    (arm),
        .lat    (entry_lat),
        .expire (expire)
    );

    l0s_os_slicer #(
        .SYMS (SYMS)
    ) i_slicer (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (in_burst),
        .sop    (sop),
        .eop    (eop)
    );

    l0s_fts_budget #(
        .NFTS_W  (NFTS_W),
        .EXT_FTS (EXT_FTS),
        .SKP_GAP (SKP_GAP)
    ) i_budget (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .ext_sync  (lnk_ctl[EXT_BIT]),
        .n_fts     (n_fts),
        .fts_done  (fts_done),
        .load_zero (load_zero),
        .burst_end (burst_end),
        .skp_due   (skp_due)
    );

    // Next-state selection for the L0 / L0s / exit-burst sequence.
    always_comb begin
        st_nxt = st;
        unique case (st)
            ST_L0:   if (expire) st_nxt = ST_L0S;
            ST_L0S:  if (tlp_req) st_nxt = load_zero ? ST_SKPF : ST_FTS;
            ST_FTS:  begin
                if (burst_end)    st_nxt = ST_SKPF;
                else if (skp_due) st_nxt = ST_SKPI;
            end
            ST_SKPI: if (eop) st_nxt = ST_FTS;
            ST_SKPF: if (eop) st_nxt = ST_L0;
            default: st_nxt = ST_L0;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_L0;
        else        st <= st_nxt;
    end

    // Lane strobes decoded from the state.
    always_comb begin
        os_fts   = (st == ST_FTS);
        os_skp   = (st == ST_SKPI) || (st == ST_SKPF);
        os_eidle = (st == ST_L0S);
        os_sop   = sop;
        state    = st;
    end

    AST_NO_ENTRY_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_L0 && !lnk_ctl[L0S_EN_BIT]) |=> (st != ST_L0S)); // R3

    AST_L0S_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_L0S && !tlp_req) |=> (st == ST_L0S)); // R4

    AST_WAKE_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_L0S && tlp_req) |=> ((st == ST_FTS || st == ST_SKPF) && os_sop)); // R5

    AST_SKP_BEFORE_L0: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_L0 && $past(st) != ST_L0) |-> ($past(st) == ST_SKPF)); // R9

endmodule

// File: tb/test_l0s_fts_sequencer.sv
// Bench: random and directed stimulus with counts compared against
// expected values computed from the requirements.
module test_l0s_fts_sequencer;

    localparam int SYMS  = 2;
    localparam int LAT_W = 12;
    localparam int OSCLK = 4 / SYMS;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [7:0]       lnk_ctl = 8'h00;
    logic [7:0]       n_fts = 8'd0;
    logic [LAT_W-1:0] entry_lat = '0;
    logic             link_idle = 1'b0;
    logic             tlp_req = 1'b0;
    logic             os_fts, os_skp, os_eidle, os_sop;
    logic [2:0]       state;

    int vectors = 0;
    int fails = 0;
    int cyc = 0;

    always #5 clk = ~clk;

    l0s_fts_sequencer #(.SYMS(SYMS), .LAT_W(LAT_W)) i_l0s_fts_sequencer (
        .clk(clk), .rst_n(rst_n), .lnk_ctl(lnk_ctl), .n_fts(n_fts),
        .entry_lat(entry_lat), .link_idle(link_idle), .tlp_req(tlp_req),
        .os_fts(os_fts), .os_skp(os_skp), .os_eidle(os_eidle),
        .os_sop(os_sop), .state(state)
    );

    function automatic int exp_fts(bit ext, int nf);
        return ext ? 4096 : nf;
    endfunction

    function automatic int exp_iskp(bit ext);
        return ext ? (4096 - 1) / 341 : 0;
    endfunction

    function automatic int exp_lat(int lat);
        return (lat == 0) ? 1 : lat;
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 190000) begin
                fails++;
                $display("FAIL watchdog: actual %0d expected below 190000", cyc);
                $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
                $finish;
            end
        end
    end

    // Measure clocks from the start of an idle run until state 1 appears.
    task automatic meas_entry(output int n);
        n = 0;
        link_idle = 1'b1;
        for (int i = 1; i <= 5000; i++) begin
            @(negedge clk);
            if (state == 3'd1) begin n = i; break; end
        end
    endtask

    // Run one exit burst from L0s and check its shape.
    task automatic do_burst(bit ext, int nf, bit hold);
        int nfts = 0, niskp = 0, nfin = 0, clks = 0;
        int ef, ei;
        ef = exp_fts(ext, nf);
        ei = exp_iskp(ext);
        lnk_ctl = {ext, 6'd0, 1'b1};
        n_fts = 8'(nf);
        link_idle = 1'b0;
        tlp_req = 1'b1;
        @(negedge clk);
        chk(state == ((ef == 0) ? 3'd4 : 3'd2) && os_sop, "R5", state, (ef == 0) ? 4 : 2);
        if (!hold) tlp_req = 1'b0;
        for (int i = 0; i < 40000; i++) begin
            if (state == 3'd0) break;
            clks++;
            if (os_sop) begin
                if (state == 3'd2 && os_fts) nfts++;
                if (state == 3'd3 && os_skp) niskp++;
                if (state == 3'd4 && os_skp) nfin++;
            end
            @(negedge clk);
        end
        chk(nfts == ef, ext ? "R7" : "R6", nfts, ef);
        chk(niskp == ei, ext ? "R8" : "R11", niskp, ei);
        chk(nfin == 1, "R9", nfin, 1);
        chk(clks == (ef + ei + 1) * OSCLK, "R9", clks, (ef + ei + 1) * OSCLK);
        if (hold) begin
            link_idle = 1'b1;
            for (int i = 0; i < int'(entry_lat) + 5; i++) @(negedge clk);
            chk(state == 3'd0, "R10", state, 0);
            tlp_req = 1'b0;
        end
    endtask

    task automatic go_l0s();
        int n;
        lnk_ctl[0] = 1'b1;
        tlp_req = 1'b0;
        meas_entry(n);
    endtask

    initial begin
        int n, lat;
        void'($urandom(32'd20240611));
        entry_lat = 12'd6;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(state == 3'd0 && !os_fts && !os_skp && !os_eidle && !os_sop, "R1", state, 0);

        // L0s disabled: long idle must not enter.
        link_idle = 1'b1;
        repeat (60) @(negedge clk);
        chk(state == 3'd0, "R3", state, 0);

        // Entry latency, random plus zero.
        lnk_ctl = 8'h01;
        for (int k = 0; k < 5; k++) begin
            lat = (k == 0) ? 0 : int'($urandom_range(1, 40));
            entry_lat = LAT_W'(lat);
            link_idle = 1'b0;
            @(negedge clk);
            meas_entry(n);
            chk(n == exp_lat(lat), "R2", n, exp_lat(lat));
            do_burst(1'b0, int'($urandom_range(1, 255)), 1'b0);
        end

        // Broken idle run restarts the count.
        entry_lat = 12'd10;
        link_idle = 1'b1;
        repeat (7) @(negedge clk);
        link_idle = 1'b0;
        @(negedge clk);
        meas_entry(n);
        chk(n == 10, "R2", n, 10);

        // Held in L0s without a request.
        repeat (20) @(negedge clk);
        chk(state == 3'd1 && os_eidle && !os_fts && !os_skp, "R4", state, 1);

        // Normal bursts: corners and random counts.
        do_burst(1'b0, 0, 1'b0);
        go_l0s();
        do_burst(1'b0, 1, 1'b0);
        go_l0s();
        do_burst(1'b0, 255, 1'b0);
        for (int k = 0; k < 4; k++) begin
            go_l0s();
            do_burst(1'b0, int'($urandom_range(0, 255)), k[0]);
        end

        // Extended sync: pulsed and held request (R10).
        go_l0s();
        do_burst(1'b1, int'($urandom_range(0, 255)), 1'b0);
        go_l0s();
        do_burst(1'b1, 3, 1'b1);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule